// File: doc/BRIEF.md
# Grid Sync H-Bridge Supervisor

This block sits beside a sine-table sequencer in a grid-tied inverter and decides when each leg of the output H-bridge may conduct. It watches a mains zero-cross sync input, checks each sync edge against where the sequencer currently is in its quarter-wave table, and keeps the bridge dark whenever the grid is missing or drifting out of phase. It also pulls the sequencer back into step by raising a one-cycle resync request that carries a fixed reload index and an upward direction.

The sequencer supplies its table index, its counting direction, and two strobes: one at the start of each half cycle and one at its end. On every half-cycle start the supervisor flips polarity. It energises the leg for the new polarity only when the most recent sync edge passed the phase check, and it always drives the opposite leg off. Power to the gate drivers stays off from reset until the first sync edge. After that it stays on.

Qualification works on two levels. The first edge after a loss of mains only re-acquires phase. A second edge, in the next positive half, must land inside the index window before any leg conducts.

Top module: `grid_sync_bridge_sup`

## Requirements
- R1: While reset is held, and right after it is released, both leg enables are high (off), gate power is low and the resync request is low.
- R2: A sync event is a high-to-low transition of `sync_in`. The input passes two synchroniser flops, so a fall driven before clock edge k shows its effect on the outputs after edge k+2. A low-to-high transition has no effect.
- R3: With mains-OK clear, a sync event acquires phase. For exactly one cycle `resync_req` goes high while `resync_index` reads 6 and `resync_up` reads 1. The half is marked positive, both legs go off, gate power rises and mains-OK is set. Once raised, gate power never falls.
- R4: Sync detection is armed at each positive half-cycle start and at reset. After one event it ignores further falls until the next positive half-cycle start.
- R5: With mains-OK set, a sync event is valid when the index is 5, 6 or 7, `seq_up` is 1 and the current half is positive. A valid event raises `resync_req` for one cycle and sets frequency-valid. After an acquisition alone, no leg conducts.
- R6: With mains-OK set, any other sync event (index 4 or below, 8 or above, `seq_up` 0, or a negative half) raises no resync request. It clears mains-OK and frequency-valid and turns both legs off at once, so the next armed event is an acquisition again.
- R7: Each `half_start` pulse toggles polarity. The first pulse after reset starts a positive half. The leg for the new half (`leg_pos_n` for positive, `leg_neg_n` for negative) is driven low only if frequency-valid is set, and the other leg is driven high. Both legs are never low together.
- R8: Frequency-valid is cleared at each positive half-cycle start. A positive half with no valid sync event therefore leaves both legs off in the following negative half.
- R9: A `half_end` pulse drives both legs high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Mains zero-cross sync, asynchronous; falling transition is the event |
| seq_index | input | IDX_W | Sequencer table index |
| seq_up | input | 1 | Sequencer direction, 1 = counting up |
| half_start | input | 1 | One-cycle strobe at the start of each half cycle |
| half_end | input | 1 | One-cycle strobe at the end of each half cycle |
| leg_pos_n | output | 1 | Positive-half leg enable, active low |
| leg_neg_n | output | 1 | Negative-half leg enable, active low |
| gate_pwr_en | output | 1 | Gate driver supply enable |
| resync_req | output | 1 | One-cycle request to reload the sequencer |
| resync_index | output | IDX_W | Index to load on a resync request (6) |
| resync_up | output | 1 | Direction to load on a resync request (up) |

## Verification
The bench walks the window edges at indices 4, 5, 7 and 8. A design with an off-by-one compare would either let a late edge energise the bridge or drop a good edge and starve it. It sends a second fall inside an already-served half and an edge during a negative half. A detector that is not disarmed, or that ignores polarity, would then set frequency-valid from the wrong edge and turn on a leg in the following half. It rejects an edge while a leg is conducting, which catches designs that only clear flags and leave the leg on. It also checks that an acquisition alone never energises a leg, which exposes a design that collapses the two-level qualification into one.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

   // Outcome of one armed sync event, decided in the cycle it is seen.
   typedef enum logic [1:0] {
      EV_NONE    = 2'd0,
      EV_ACQUIRE = 2'd1,
      EV_ACCEPT  = 2'd2,
      EV_REJECT  = 2'd3
   } sync_verdict_e;

   // Active-low leg drive pair.
   typedef struct packed {
      logic pos_n;
      logic neg_n;
   } leg_pair_t;

   localparam leg_pair_t LEGS_OFF = '{pos_n: 1'b1, neg_n: 1'b1};

endpackage

// File: rtl/gsb_sync_edge.sv
module gsb_sync_edge #(
   parameter int STAGES       = 2,
   parameter bit DETECT_FALL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic event_pulse
);
   // The idle level is the one the detected transition leaves.
   localparam bit IDLE_LVL = DETECT_FALL;

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= IDLE_LVL;
               else        chain[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= IDLE_LVL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= IDLE_LVL;
      else        last_q <= chain[STAGES-1];
   end

   generate
      if (DETECT_FALL) begin : g_fall
         assign event_pulse = last_q & ~chain[STAGES-1];
      end else begin : g_rise
         assign event_pulse = ~last_q & chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gsb_qualifier.sv
module gsb_qualifier
   import gsb_pkg::*;
#(
   parameter int IDX_W   = 5,
   parameter int WIN_MIN = 5,
   parameter int WIN_MAX = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_event,
   input  logic [IDX_W-1:0] seq_index,
   input  logic             seq_up,
   input  logic             pos_half,
   input  logic             pos_start,
   output sync_verdict_e    verdict,
   output logic             armed,
   output logic             mains_ok,
   output logic             freq_valid,
   output logic             resync_req
);
   localparam logic [IDX_W-1:0] LO_V = IDX_W'(WIN_MIN);
   localparam logic [IDX_W-1:0] HI_V = IDX_W'(WIN_MAX);

   logic taken;
   logic in_window;

   assign taken     = sync_event & armed;
   assign in_window = (seq_index >= LO_V) && (seq_index <= HI_V);

   always_comb begin
      verdict = EV_NONE;
      if (taken) begin
         if (!mains_ok)                          verdict = EV_ACQUIRE;
         else if (in_window && seq_up && pos_half) verdict = EV_ACCEPT;
         else                                    verdict = EV_REJECT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b1;
         mains_ok   <= 1'b0;
         freq_valid <= 1'b0;
         resync_req <= 1'b0;
      end else begin
         resync_req <= (verdict == EV_ACQUIRE) || (verdict == EV_ACCEPT);
         // A new positive half re-opens the detector and withdraws the
         // permission earned in the previous cycle.
         if (pos_start) begin
            armed      <= 1'b1;
            freq_valid <= 1'b0;
         end
         if (taken) armed <= 1'b0;
         unique case (verdict)
            EV_ACQUIRE: mains_ok <= 1'b1;
            EV_ACCEPT:  freq_valid <= 1'b1;
            EV_REJECT: begin
               mains_ok   <= 1'b0;
               freq_valid <= 1'b0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/gsb_leg_ctrl.sv
module gsb_leg_ctrl
   import gsb_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          half_start,
   input  logic          half_end,
   input  sync_verdict_e verdict,
   input  logic          freq_valid,
   output logic          pos_half,
   output leg_pair_t     legs,
   output logic          gate_en
);
   logic energise;

   // A reject in the same cycle as a half start withdraws permission.
   assign energise = freq_valid && (verdict != EV_REJECT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_half <= 1'b0;
         legs     <= LEGS_OFF;
         gate_en  <= 1'b0;
      end else begin
         if (verdict == EV_ACQUIRE) begin
            pos_half <= 1'b1;
            legs     <= LEGS_OFF;
            gate_en  <= 1'b1;
         end
         if (verdict == EV_REJECT) legs <= LEGS_OFF;
         if (half_end)             legs <= LEGS_OFF;
         if (half_start) begin
            pos_half <= ~pos_half;
            if (!pos_half) begin
               legs.pos_n <= ~energise;
               legs.neg_n <= 1'b1;
            end else begin
               legs.neg_n <= ~energise;
               legs.pos_n <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/grid_sync_bridge_sup.sv
module grid_sync_bridge_sup
   import gsb_pkg::*;
#(
   parameter int IDX_W        = 5,
   parameter int WIN_MIN      = 5,
   parameter int WIN_MAX      = 7,
   parameter int RESYNC_IDX   = 6,
   parameter int SYNC_STAGES  = 2,
   parameter bit SYNC_FALLING = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_in,
   input  logic [IDX_W-1:0] seq_index,
   input  logic             seq_up,
   input  logic             half_start,
   input  logic             half_end,
   output logic             leg_pos_n,
   output logic             leg_neg_n,
   output logic             gate_pwr_en,
   output logic             resync_req,
   output logic [IDX_W-1:0] resync_index,
   output logic             resync_up
);
   localparam logic [IDX_W-1:0] RELOAD_V = IDX_W'(RESYNC_IDX);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 2");
      end
      if (WIN_MIN > WIN_MAX) begin : g_bad_window
         $error("WIN_MIN must not exceed WIN_MAX");
      end
      if (WIN_MAX >= (1 << IDX_W)) begin : g_bad_width
         $error("WIN_MAX does not fit in IDX_W bits");
      end
      if (RESYNC_IDX < WIN_MIN || RESYNC_IDX > WIN_MAX) begin : g_bad_reload
         $error("RESYNC_IDX must lie inside the acceptance window");
      end
   endgenerate

   logic          sync_fall;
   logic          pos_half;
   logic          pos_start;
   logic          armed;
   logic          mains_ok;
   logic          freq_valid;
   sync_verdict_e verdict;
   leg_pair_t     legs;

   assign pos_start = half_start & ~pos_half;

   gsb_sync_edge #(
      .STAGES      (SYNC_STAGES),
      .DETECT_FALL (SYNC_FALLING)
   ) u_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin         (sync_in),
      .event_pulse (sync_fall)
   );

   gsb_qualifier #(
      .IDX_W   (IDX_W),
      .WIN_MIN (WIN_MIN),
      .WIN_MAX (WIN_MAX)
   ) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_event (sync_fall),
      .seq_index  (seq_index),
      .seq_up     (seq_up),
      .pos_half   (pos_half),
      .pos_start  (pos_start),
      .verdict    (verdict),
      .armed      (armed),
      .mains_ok   (mains_ok),
      .freq_valid (freq_valid),
      .resync_req (resync_req)
   );

   gsb_leg_ctrl u_legs (
      .clk        (clk),
      .rst_n      (rst_n),
      .half_start (half_start),
      .half_end   (half_end),
      .verdict    (verdict),
      .freq_valid (freq_valid),
      .pos_half   (pos_half),
      .legs       (legs),
      .gate_en    (gate_pwr_en)
   );

   assign leg_pos_n    = legs.pos_n;
   assign leg_neg_n    = legs.neg_n;
   assign resync_index = RELOAD_V;
   assign resync_up    = 1'b1;

endmodule

// File: rtl/gsb_checker.sv
module gsb_checker (
   input logic clk,
   input logic rst_n,
   input logic leg_pos_n,
   input logic leg_neg_n,
   input logic gate_pwr_en,
   input logic resync_req,
   input logic half_start,
   input logic half_end,
   input logic sync_fall,
   input logic armed,
   input logic mains_ok,
   input logic freq_valid,
   input logic pos_half
);
   p_legs_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      leg_pos_n || leg_neg_n);

   p_leg_needs_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!leg_pos_n || !leg_neg_n) |-> gate_pwr_en);

   p_gate_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gate_pwr_en |=> gate_pwr_en);

   p_leg_needs_mains_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!leg_pos_n || !leg_neg_n) |-> mains_ok);

   p_half_end_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (half_end && !half_start) |=> (leg_pos_n && leg_neg_n));

   p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_fall && armed) |=> !armed);

   p_resync_from_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resync_req) |-> $past(sync_fall && armed));

   p_fv_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (half_start && !pos_half && !(sync_fall && armed)) |=> !freq_valid);

endmodule

bind grid_sync_bridge_sup gsb_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .leg_pos_n   (leg_pos_n),
   .leg_neg_n   (leg_neg_n),
   .gate_pwr_en (gate_pwr_en),
   .resync_req  (resync_req),
   .half_start  (half_start),
   .half_end    (half_end),
   .sync_fall   (sync_fall),
   .armed       (armed),
   .mains_ok    (mains_ok),
   .freq_valid  (freq_valid),
   .pos_half    (pos_half)
);

// File: tb/tb_grid_sync_bridge_sup.sv
module tb_grid_sync_bridge_sup;
   localparam int IDX_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sync_in = 1'b1;
   logic [IDX_W-1:0] seq_index = '0;
   logic             seq_up = 1'b0;
   logic             half_start = 1'b0;
   logic             half_end = 1'b0;
   logic             leg_pos_n, leg_neg_n, gate_pwr_en, resync_req, resync_up;
   logic [IDX_W-1:0] resync_index;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   int cycles = 0;

   // results of the latest sync_fall call
   logic req_n2, req_n3, req_rise;

   always #5 clk = ~clk;

   grid_sync_bridge_sup dut (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .seq_index(seq_index),
      .seq_up(seq_up), .half_start(half_start), .half_end(half_end),
      .leg_pos_n(leg_pos_n), .leg_neg_n(leg_neg_n), .gate_pwr_en(gate_pwr_en),
      .resync_req(resync_req), .resync_index(resync_index), .resync_up(resync_up)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // legs packed as {pos_n, neg_n}: 3 = both off, 1 = positive on, 2 = negative on
   task automatic chk_legs(input string tag, input int exp);
      chk(tag, int'({leg_pos_n, leg_neg_n}), exp);
   endtask

   task automatic hs();
      @(negedge clk) half_start = 1'b1;
      @(negedge clk) half_start = 1'b0;
   endtask

   task automatic he();
      @(negedge clk) half_end = 1'b1;
      @(negedge clk) half_end = 1'b0;
   endtask

   task automatic sync_fall(input int idx, input bit up);
      @(negedge clk);
      seq_index = IDX_W'(idx);
      seq_up    = up;
      sync_in   = 1'b0;
      @(negedge clk);
      @(negedge clk) req_n2 = resync_req;
      @(negedge clk) req_n3 = resync_req;
      sync_in  = 1'b1;
      req_rise = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk) if (resync_req) req_rise = 1'b1;
      end
   endtask

   task automatic t_reset();
      chk_legs("R1 legs at reset", 3);
      chk("R1 gate at reset", int'(gate_pwr_en), 0);
      chk("R1 resync at reset", int'(resync_req), 0);
   endtask

   task automatic t_acquire();
      hs();
      chk_legs("R7 positive half without freq-valid", 3);
      sync_fall(0, 1'b0);
      chk("R2 no effect before third edge", int'(req_n2), 0);
      chk("R3 acquisition resync", int'(req_n3), 1);
      chk("R3 reload index", int'(resync_index), 6);
      chk("R3 reload direction", int'(resync_up), 1);
      chk("R3 gate power on", int'(gate_pwr_en), 1);
      chk("R2 rising edge and pulse width", int'(req_rise), 0);
      chk_legs("R3 legs off after acquire", 3);
   endtask

   task automatic t_disarmed();
      sync_fall(6, 1'b1);
      chk("R4 second edge ignored", int'(req_n3), 0);
      hs();
      chk_legs("R4 ignored edge grants nothing", 3);
      hs();
   endtask

   task automatic t_valid(input int idx, input string tag);
      sync_fall(idx, 1'b1);
      chk({tag, " valid edge resync"}, int'(req_n3), 1);
      hs();
      chk_legs({tag, " negative leg on"}, 2);
   endtask

   task automatic t_full_cycle();
      t_valid(6, "R5 index 6");
      he();
      chk_legs("R9 half_end turns legs off", 3);
      hs();
      chk_legs("R7 positive leg on, negative off", 1);
   endtask

   task automatic t_reject_live();
      sync_fall(2, 1'b1);
      chk("R6 early edge no resync", int'(req_n3), 0);
      chk_legs("R6 reject drops live leg", 3);
      hs(); hs();
      sync_fall(0, 1'b0);
      chk("R6 next edge reacquires", int'(req_n3), 1);
      hs();
      chk_legs("R5 acquire alone grants no leg", 3);
      hs();
   endtask

   task automatic t_no_edge_half();
      he();
      hs();
      chk_legs("R8 no edge in positive half", 3);
      hs();
   endtask

   task automatic t_reject(input int idx, input bit up, input string tag);
      sync_fall(idx, up);
      chk({tag, " no resync"}, int'(req_n3), 0);
      chk_legs({tag, " legs off"}, 3);
      hs(); hs();
      sync_fall(0, 1'b0);
      chk({tag, " reacquire"}, int'(req_n3), 1);
      hs();
      chk_legs({tag, " mains-OK was cleared"}, 3);
      hs();
   endtask

   task automatic t_neg_half_edge();
      hs();
      sync_fall(6, 1'b1);
      chk("R6 edge in negative half no resync", int'(req_n3), 0);
      hs();
      sync_fall(6, 1'b1);
      chk("R6 after negative-half reject reacquires", int'(req_n3), 1);
      hs();
      chk_legs("R6 negative-half edge cleared mains-OK", 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_acquire();
      t_disarmed();
      t_full_cycle();
      t_reject_live();
      t_valid(5, "R5 index 5");
      hs();
      chk_legs("R7 positive leg after index 5", 1);
      t_no_edge_half();
      t_valid(7, "R5 index 7");
      hs();
      t_reject(8, 1'b1, "R6 index 8");
      t_reject(4, 1'b1, "R6 index 4");
      t_reject(6, 1'b0, "R6 direction down");
      t_neg_half_edge();
      chk("R3 gate power held", int'(gate_pwr_en), 1);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule